// File: doc/BRIEF.md
# Programmable Time-Base Interval Timer

This block is a free-running interval timer driven directly by the oscillator clock. It divides that clock by one of four period lengths, which software selects. At the end of every period it raises a timeout flag. The flag, an interrupt-enable bit and the 2-bit period select all sit in one small control/status register. The interrupt output is the flag gated by the enable, so the timer can wake the system from its low-power halt state.

A change to the period select does not disturb the period that is already running. The new length is captured into a shadow register only when the current period wraps, so the ticks never shift and the timer can serve as a real-time clock. The flag is cleared as a side effect of reading the register, not by writing to it. Software that performs a read-modify-write on the register therefore clears a pending flag without meaning to.

Top module: `tbase_timer`

## Requirements
- R1: After a synchronous active-high reset, the register reads 0x00 (select 00, interrupt disabled, flag clear), `irq` is low and the counter is zero, so the first timeout arrives exactly CNT0 clocks after reset is released.
- R2: The period in clocks follows the active select code: 00 gives CNT0, 01 gives CNT1, 10 gives CNT2, 11 gives CNT3 (defaults 16000, 32000, 80000, 200000). The counter runs from 0 to N-1 and wraps to zero.
- R3: A write that changes the select field does not alter the running period. The new length applies from the period that starts at the next wrap.
- R4: The flag (register bit 0) is set by hardware on the clock edge where the counter wraps.
- R5: A cycle with `reg_rd` high clears the flag at the next edge. A read-modify-write (a read followed by writing back the value read) therefore leaves the flag clear.
- R6: Writes never change the flag. Writing 1 to bit 0 does not set it, and writing 0 to bit 0 does not clear it.
- R7: The register layout is bits [3:2] select, bit 1 interrupt enable, bit 0 flag, bits [7:4] read as zero. A write updates select and enable at the next edge.
- R8: `irq` is high exactly when both the flag and the interrupt enable are set.
- R9: When a period ends in the same cycle as a read, the flag is set after that edge, so the timeout is not lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock; also the counting clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe for one cycle |
| reg_rd | input | 1 | Register read strobe; clears the flag |
| reg_wdata | input | 8 | Write data (select [3:2], enable [1]) |
| reg_rdata | output | 8 | Current register contents, always visible |
| irq | output | 1 | Timeout interrupt / wake-up request |

## Verification
The hardest situation to reach from the ports is a read strobe that lands in the very cycle the counter sits at N-1. In that cycle the set and the clear collide, and only the priority of the set keeps the timeout. The bench notes the cycle in which the flag rose and adds the period length to predict the next wrap. It leaves the flag pending, then drives the read in exactly the cycle before that wrap edge. A second hard case is a select change in the middle of a period. The bench writes the new code a few cycles into a period and measures both the current interval and the one that follows it.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

    typedef logic [1:0] tb_sel_t;

    localparam int unsigned REG_W   = 8;
    localparam int unsigned FLAG_B  = 0;
    localparam int unsigned IEN_B   = 1;
    localparam int unsigned SEL_LO  = 2;
    localparam int unsigned SEL_HI  = 3;
    localparam int unsigned N_CODES = 4;

    typedef struct packed {
        tb_sel_t sel;
        logic    ien;
        logic    flag;
    } csr_t;

endpackage

// File: rtl/tbase_div.sv
module tbase_div
    import tbase_pkg::*;
#(
    parameter int unsigned N0 = 16000,
    parameter int unsigned N1 = 32000,
    parameter int unsigned N2 = 80000,
    parameter int unsigned N3 = 200000,
    parameter int unsigned CW = 18
) (
    input  logic    clk,
    input  logic    rst,
    input  tb_sel_t sel_i,
    output logic    wrap_o
);

    localparam int unsigned LENS [N_CODES] = '{N0, N1, N2, N3};

    typedef struct packed {
        logic [CW-1:0] cnt;
        tb_sel_t       per;
    } div_t;

    div_t s_d, s_q;
    logic [N_CODES-1:0] at_last;

    // one terminal comparator per encoding
    for (genvar g = 0; g < N_CODES; g++) begin : g_term
        localparam logic [CW-1:0] LAST = CW'(LENS[g] - 1);
        assign at_last[g] = (s_q.cnt == LAST);
    end

    assign wrap_o = at_last[s_q.per];

    always_comb begin
        s_d = s_q;
        if (wrap_o) begin
            s_d.cnt = '0;
            s_d.per = sel_i;      // shadow reloads only at the period boundary
        end else begin
            s_d.cnt = s_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R3
    per_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wrap_o |=> $stable(s_q.per));

    // R2
    wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        wrap_o |=> (s_q.cnt == '0));

endmodule

// File: rtl/tbase_csr.sv
module tbase_csr
    import tbase_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  logic             rd_i,
    input  logic [2:0]       wfield_i,
    input  logic             wrap_i,
    output tb_sel_t          sel_o,
    output logic             ien_o,
    output logic             flag_o,
    output logic [REG_W-1:0] rdata_o
);

    csr_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_i) begin
            r_d.sel = wfield_i[2:1];
            r_d.ien = wfield_i[0];
        end
        // a timeout beats a clearing read in the same cycle
        if (wrap_i) begin
            r_d.flag = 1'b1;
        end else if (rd_i) begin
            r_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sel_o  = r_q.sel;
    assign ien_o  = r_q.ien;
    assign flag_o = r_q.flag;

    always_comb begin
        rdata_o               = '0;
        rdata_o[SEL_HI:SEL_LO] = r_q.sel;
        rdata_o[IEN_B]        = r_q.ien;
        rdata_o[FLAG_B]       = r_q.flag;
    end

    // R4
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        wrap_i |=> r_q.flag);

    // R5
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_i && !wrap_i) |=> !r_q.flag);

    // R6
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_i && !wrap_i) |=> $stable(r_q.flag));

endmodule

// File: rtl/tbase_timer.sv
module tbase_timer
    import tbase_pkg::*;
#(
    parameter int unsigned CNT0 = 16000,
    parameter int unsigned CNT1 = 32000,
    parameter int unsigned CNT2 = 80000,
    parameter int unsigned CNT3 = 200000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq
);

    localparam int unsigned MAX01 = (CNT0 > CNT1) ? CNT0 : CNT1;
    localparam int unsigned MAX23 = (CNT2 > CNT3) ? CNT2 : CNT3;
    localparam int unsigned MAXN  = (MAX01 > MAX23) ? MAX01 : MAX23;
    localparam int unsigned CW    = (MAXN > 2) ? $clog2(MAXN) : 1;

    tb_sel_t sel_w;
    logic    ien_w, flag_w, wrap_w;
    logic    unused_wbits;

    assign unused_wbits = ^{reg_wdata[7:4], reg_wdata[FLAG_B]};

    tbase_div #(
        .N0 (CNT0),
        .N1 (CNT1),
        .N2 (CNT2),
        .N3 (CNT3),
        .CW (CW)
    ) u_div (
        .clk    (clk),
        .rst    (rst),
        .sel_i  (sel_w),
        .wrap_o (wrap_w)
    );

    tbase_csr u_csr (
        .clk      (clk),
        .rst      (rst),
        .wr_i     (reg_wr),
        .rd_i     (reg_rd),
        .wfield_i (reg_wdata[SEL_HI:IEN_B]),
        .wrap_i   (wrap_w),
        .sel_o    (sel_w),
        .ien_o    (ien_w),
        .flag_o   (flag_w),
        .rdata_o  (reg_rdata)
    );

    assign irq = flag_w & ien_w;

    // R8
    irq_needs_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(wrap_w) || $past(reg_wr)));

endmodule

// File: tb/test_tbase_timer.sv
`timescale 1ns/1ps
module test_tbase_timer;

    localparam int unsigned T0 = 12;
    localparam int unsigned T1 = 24;
    localparam int unsigned T2 = 40;
    localparam int unsigned T3 = 64;

    // {select[9:8], expected period[7:0]}
    localparam int NV = 4;
    localparam logic [9:0] VEC [NV] = '{
        {2'b01, 8'd24},
        {2'b11, 8'd64},
        {2'b00, 8'd12},
        {2'b10, 8'd40}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] wd = '0;
    logic [7:0] rdat;
    logic       irq;
    int         cyc = 0;
    int         n_run = 0, n_fail = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    always_ff @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    tbase_timer #(.CNT0(T0), .CNT1(T1), .CNT2(T2), .CNT3(T3)) i_tbase_timer (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (wr),
        .reg_rd    (rd),
        .reg_wdata (wd),
        .reg_rdata (rdat),
        .irq       (irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic do_reset;
        rst = 1'b1; wr = 1'b0; rd = 1'b0; wd = '0;
        tick; tick;
        rst = 1'b0;
    endtask

    task automatic reg_write(input logic [7:0] v);
        wr = 1'b1; wd = v;
        tick;
        wr = 1'b0;
    endtask

    task automatic reg_read;
        rd = 1'b1;
        tick;
        rd = 1'b0;
    endtask

    task automatic wait_rise(output int c);
        while (rdat[0]) tick;
        while (!rdat[0]) tick;
        c = cyc;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
            $finish;
        end
    end

    initial begin
        int r1, r2;
        logic [7:0] v;

        // R1 reset state
        do_reset;
        chk(rdat == 8'h00, "R1 rdata", rdat, 0);
        chk(irq == 1'b0, "R1 irq", irq, 0);
        wait_rise(r1);
        chk(r1 == T0, "R1 first timeout cycle", r1, T0);

        // R2 R4 table walk over the four encodings
        for (int i = 0; i < NV; i++) begin
            do_reset;
            reg_write({4'b0, VEC[i][9:8], 2'b00});
            wait_rise(r1);
            reg_read;
            wait_rise(r2);
            chk((r2 - r1) == int'(VEC[i][7:0]), "R2 R4 period", r2 - r1, int'(VEC[i][7:0]));
        end

        // R3 deferred period change
        do_reset;
        while (cyc != 5) tick;
        reg_write(8'h0C);
        chk(rdat[3:2] == 2'b11, "R7 select readback", rdat[3:2], 3);
        wait_rise(r1);
        chk(r1 == T0, "R3 running period kept", r1, T0);
        reg_read;
        wait_rise(r2);
        chk(r2 == T0 + T3, "R3 new period next", r2, T0 + T3);

        // R6 writes to flag ignored, R5 read clears
        reg_write(8'h0C);
        chk(rdat[0] == 1'b1, "R6 write 0 keeps flag", rdat[0], 1);
        reg_read;
        chk(rdat[0] == 1'b0, "R5 read clears", rdat[0], 0);
        reg_write(8'h0D);
        chk(rdat[0] == 1'b0, "R6 write 1 no set", rdat[0], 0);

        // R8 interrupt gating and R5 read-modify-write
        do_reset;
        reg_write(8'h02);
        wait_rise(r1);
        chk(irq == 1'b1, "R8 irq on", irq, 1);
        reg_write(8'h00);
        chk(irq == 1'b0 && rdat[0] == 1'b1, "R8 irq masked", irq, 0);
        reg_write(8'h02);
        chk(irq == 1'b1, "R8 irq re-enabled", irq, 1);
        v = rdat;
        reg_read;
        reg_write(v);
        chk(rdat[0] == 1'b0, "R5 rmw clears flag", rdat[0], 0);
        chk(irq == 1'b0, "R8 irq low after clear", irq, 0);

        // R7 register layout
        reg_write(8'hFF);
        chk(rdat[7:4] == 4'h0, "R7 upper bits zero", rdat[7:4], 0);
        chk(rdat[3:1] == 3'b111, "R7 select and enable", rdat[3:1], 7);

        // R9 read collides with wrap
        do_reset;
        wait_rise(r1);
        while (cyc != r1 + T0 - 1) tick;
        reg_read;
        chk(rdat[0] == 1'b1, "R9 set wins over read", rdat[0], 1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule